// File: doc/BRIEF.md
# Dual-Core Package Power-State Arbiter

This block is the central power-management decision point for a package that holds two processor cores. Every bus clock it looks at the power-state code that each core reports, at the stop-clock request pin, and at a strobe that marks the response phase of the stop-grant acknowledge bus cycle. From these inputs it drives a two-bit package state, a one-cycle stop-grant entry strobe, a deeper-sleep request, and a sticky error flag for the entry timer.

With stop-clock idle, the package state follows the combined core states one clock later. It is normal while any core is running or halted, deeper-sleep when both cores sit in C4, and a light idle state for every other mix of sleeping cores. When stop-clock is asserted, a bus-clock timer starts on the acknowledge response strobe. The package enters stop-grant after a programmed delay, and never later than a fixed window of 20 clocks. The state held just before stop-grant is saved and put back when stop-clock is released. Voltage control and the electrical side of deeper sleep lie outside this block.

Top module: `psa_pkg_arbiter`

## Requirements
- R1: Core codes are 0 running, 1 auto-halt, 2 wait-halt, 3 C2, 4 C3, 5 C4, and codes 6 and 7 count as a sleeping non-C4 core. Package codes are 0 normal, 1 stop-grant, 2 deeper-sleep, 3 light idle. With stop-clock low, if any core reports code 0, 1 or 2 at a clock edge, the package state after that edge is 0.
- R2: With stop-clock low and no core at 0, 1 or 2, the package state after the edge is 2 when both cores report 5, and 3 otherwise.
- R3: The deeper-sleep request is high only while the package state is 2, both cores report 5 and stop-clock is low. One core alone in C4 never raises it.
- R4: The deeper-sleep request drops in the same clock, with no edge needed, when either core leaves C4.
- R5: If the acknowledge strobe is sampled at edge T while stop-clock is high and no entry is already under way, the package state becomes 1 after edge T+D, where D is the delay setting (1 to 20). The entry strobe is high for exactly that one cycle.
- R6: A delay setting outside 1..20 still gives entry after edge T+20, and it sets the error flag, which stays high until reset.
- R7: When stop-clock falls while the state is 1, the state after the next edge is the one held before entry. After that it tracks the cores again.
- R8: Stop-clock beats deeper sleep. While stop-clock is high, the request is low and a both-C4 condition shows as state 3 rather than 2.
- R9: An acknowledge strobe while stop-clock is low has no effect. A later stop-clock assertion without a new strobe never reaches state 1.
- R10: If stop-clock falls before entry, the timer is cleared and no entry strobe appears.
- R11: A synchronous active-low reset gives state 0, with the request, the strobe and the error flag all low, and clears the timer and the saved state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_states | input | 6 | Core power codes, core 0 in bits 2:0 |
| stop_clk | input | 1 | Stop-clock request, active high |
| ack_resp | input | 1 | Response phase of the stop-grant acknowledge cycle |
| delay_cfg | input | 5 | Entry delay in bus clocks after the response phase |
| pkg_state | output | 2 | Package power state |
| sg_enter | output | 1 | One-cycle stop-grant entry strobe |
| sleep_req | output | 1 | Deeper-sleep package request |
| timer_err | output | 1 | Sticky flag: entry delay setting was out of range |

## Verification
The assertions assume that the acknowledge strobe comes as a single-cycle pulse, and only after stop-clock has been raised. They also assume that the core codes and the delay setting change only between clock edges. The random phase changes the core codes freely with stop-clock low. Each stop-grant sequence raises stop-clock first, pulses the strobe for one cycle, and then holds the delay steady until entry or release. Out-of-range delays and strobes sent with stop-clock low are given only as directed cases.

// File: rtl/psa_types_pkg.sv
// Shared encodings for the package power-state arbiter.
// Assumes three-bit core codes and a two-bit package state.
package psa_types_pkg;

    localparam int CS_W = 3;

    typedef enum logic [CS_W-1:0] {
        CS_RUN   = 3'd0,
        CS_HALT  = 3'd1,
        CS_WAIT  = 3'd2,
        CS_C2    = 3'd3,
        CS_C3    = 3'd4,
        CS_C4    = 3'd5,
        CS_RSV6  = 3'd6,
        CS_RSV7  = 3'd7
    } core_state_e;

    typedef enum logic [1:0] {
        PK_NORMAL = 2'd0,
        PK_STOPG  = 2'd1,
        PK_DEEP   = 2'd2,
        PK_LIGHT  = 2'd3
    } pkg_state_e;

endpackage

// File: rtl/psa_core_merge.sv
// Combines the per-core power codes into one base package state.
// Assumes: codes are stable around the clock edge; codes 6 and 7 are
// treated as a sleeping core that is not in C4.
module psa_core_merge
    import psa_types_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic [NUM_CORES*CS_W-1:0] core_states,
    output pkg_state_e                base_state,
    output logic                      all_c4
);

    logic [NUM_CORES-1:0] awake;
    logic [NUM_CORES-1:0] in_c4;

    // Classify each core on its own slice of the input vector.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        core_state_e cs;
        always_comb begin
            cs       = core_state_e'(core_states[i*CS_W +: CS_W]);
            awake[i] = (cs == CS_RUN) || (cs == CS_HALT) || (cs == CS_WAIT);
            in_c4[i] = (cs == CS_C4);
        end
    end

    // Pick the package state: any awake core wins, then all-C4, else light.
    always_comb begin
        all_c4 = &in_c4;
        if (|awake)
            base_state = PK_NORMAL;
        else if (all_c4)
            base_state = PK_DEEP;
        else
            base_state = PK_LIGHT;
    end

endmodule

// File: rtl/psa_sg_timer.sv
// Bus-clock timer for stop-grant entry. It is armed by the acknowledge
// response strobe while stop-clock is high, and it fires when the count
// reaches the delay setting or the hard window limit.
// Assumes the strobe is a single-cycle pulse.
module psa_sg_timer #(
    parameter int MAX_WIN = 20,
    parameter int CNT_W   = $clog2(MAX_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_clk,
    input  logic             ack_resp,
    input  logic             in_stopg,
    input  logic [CNT_W-1:0] delay_cfg,
    output logic             fire,
    output logic             overrun
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WIN);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             running_q;
    logic [CNT_W-1:0] cnt_q;

    // Fire decision from the present count.
    always_comb begin
        fire    = running_q && ((cnt_q == delay_cfg) || (cnt_q == LIMIT));
        overrun = running_q && (cnt_q == LIMIT) && (delay_cfg != LIMIT);
    end

    // Arm, advance or clear the entry counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!stop_clk || fire) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!running_q && ack_resp && !in_stopg) begin
            running_q <= 1'b1;
            cnt_q     <= ONE;
        end else if (running_q) begin
            cnt_q     <= cnt_q + ONE;
        end
    end

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R6

    AST_IDLE_WITHOUT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_clk |=> !running_q); // R10

    AST_NO_ARM_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_clk && !running_q) |=> !fire); // R9

endmodule

// File: rtl/psa_state_ctl.sv
// Holds the package state, the state saved at stop-grant entry, the
// entry strobe and the sticky timer error. It also forms the
// deeper-sleep request.
// Assumes base_state and all_c4 come from the live core codes.
module psa_state_ctl
    import psa_types_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pkg_state_e base_state,
    input  logic       all_c4,
    input  logic       stop_clk,
    input  logic       fire,
    input  logic       overrun,
    output pkg_state_e state_q,
    output logic       sg_strobe_q,
    output logic       err_q,
    output logic       sleep_req
);

    pkg_state_e saved_q;
    pkg_state_e state_d;

    // Next package state: timer entry, hold or restore, else follow cores.
    always_comb begin
        if (fire)
            state_d = PK_STOPG;
        else if (state_q == PK_STOPG)
            state_d = stop_clk ? PK_STOPG : saved_q;
        else if (stop_clk && (base_state == PK_DEEP))
            state_d = PK_LIGHT;
        else
            state_d = base_state;
    end

    // Register the state, the saved state, the strobe and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= PK_NORMAL;
            saved_q     <= PK_NORMAL;
            sg_strobe_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            sg_strobe_q <= fire;
            if (fire)
                saved_q <= state_q;
            if (overrun)
                err_q   <= 1'b1;
        end
    end

    // Deeper-sleep request drops at once when a core leaves C4 or stop-clock rises.
    always_comb begin
        sleep_req = (state_q == PK_DEEP) && all_c4 && !stop_clk;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sg_strobe_q |=> !sg_strobe_q); // R5

    AST_STROBE_IN_SG: assert property (@(posedge clk) disable iff (!rst_n)
        sg_strobe_q |-> (state_q == PK_STOPG)); // R5

    AST_STOP_BEATS_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clk |-> !sleep_req); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (state_q == PK_NORMAL) && !err_q && !sg_strobe_q); // R11

endmodule

// File: rtl/psa_pkg_arbiter.sv
// Top of the package power-state arbiter. It links the core merge, the
// stop-grant timer and the state controller.
// Assumes a single bus clock and a synchronous active-low reset.
module psa_pkg_arbiter
    import psa_types_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int MAX_WIN   = 20,
    localparam int CNT_W    = $clog2(MAX_WIN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES*CS_W-1:0] core_states,
    input  logic                      stop_clk,
    input  logic                      ack_resp,
    input  logic [CNT_W-1:0]          delay_cfg,
    output logic [1:0]                pkg_state,
    output logic                      sg_enter,
    output logic                      sleep_req,
    output logic                      timer_err
);

    pkg_state_e base_state;
    pkg_state_e state_q;
    logic       all_c4;
    logic       fire;
    logic       overrun;

    psa_core_merge #(.NUM_CORES(NUM_CORES)) u_merge (
        .core_states (core_states),
        .base_state  (base_state),
        .all_c4      (all_c4)
    );

    psa_sg_timer #(.MAX_WIN(MAX_WIN), .CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_clk  (stop_clk),
        .ack_resp  (ack_resp),
        .in_stopg  (state_q == PK_STOPG),
        .delay_cfg (delay_cfg),
        .fire      (fire),
        .overrun   (overrun)
    );

    psa_state_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_state  (base_state),
        .all_c4      (all_c4),
        .stop_clk    (stop_clk),
        .fire        (fire),
        .overrun     (overrun),
        .state_q     (state_q),
        .sg_strobe_q (sg_enter),
        .err_q       (timer_err),
        .sleep_req   (sleep_req)
    );

    // Drive the plain-typed state port.
    always_comb begin
        pkg_state = state_q;
    end

    AST_AWAKE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!stop_clk) && ($past(base_state) == PK_NORMAL) && ($past(state_q) != PK_STOPG))
        |-> (pkg_state == 2'd0)); // R1

    AST_SLEEP_NEEDS_C4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> $past(all_c4)); // R3

endmodule

// File: tb/psa_pkg_arbiter_tb.sv
module psa_pkg_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] c0 = 3'd0, c1 = 3'd0;
    logic       stop_clk = 1'b0, ack_resp = 1'b0;
    logic [4:0] delay_cfg = 5'd5;
    logic [1:0] pkg_state;
    logic       sg_enter, sleep_req, timer_err;

    int checks = 0, errors = 0;
    logic [1:0] exp_pkg;

    always #10 clk = ~clk;

    psa_pkg_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .core_states({c1, c0}),
        .stop_clk(stop_clk), .ack_resp(ack_resp), .delay_cfg(delay_cfg),
        .pkg_state(pkg_state), .sg_enter(sg_enter),
        .sleep_req(sleep_req), .timer_err(timer_err)
    );

    function automatic logic [1:0] base_of(input logic [2:0] a, input logic [2:0] b);
        if (a <= 3'd2 || b <= 3'd2) return 2'd0;
        if (a == 3'd5 && b == 3'd5) return 2'd2;
        return 2'd3;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Runs a stop-grant entry and checks its timing; returns with state 1.
    task automatic enter_sg(input logic [4:0] cfg, input int expect_at);
        delay_cfg = cfg;
        stop_clk = 1'b1;
        step();
        ack_resp = 1'b1;
        step();
        ack_resp = 1'b0;
        for (int k = 1; k < expect_at; k++) begin
            step();
            if (pkg_state == 2'd1 || sg_enter) chk("R5 early entry", pkg_state, 99);
        end
        step();
        chk("R5 entry state", pkg_state, 1);
        chk("R5 entry strobe", sg_enter, 1);
        step();
        chk("R5 strobe single", sg_enter, 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        // R11 reset state
        step(); step();
        chk("R11 state", pkg_state, 0);
        chk("R11 sleep", sleep_req, 0);
        chk("R11 strobe", sg_enter, 0);
        chk("R11 err", timer_err, 0);
        rst_n = 1'b1;

        // R1 R2 R3 random core mixes with stop-clock low
        for (int i = 0; i < 300; i++) begin
            c0 = 3'($urandom_range(0, 7));
            c1 = 3'($urandom_range(0, 7));
            if (($urandom & 3) == 0) begin c0 = 3'd5; c1 = 3'd5; end
            exp_pkg = base_of(c0, c1);
            step();
            chk(exp_pkg == 2'd0 ? "R1 normal" : "R2 idle state", pkg_state, exp_pkg);
            chk("R3 sleep", sleep_req, (exp_pkg == 2'd2) ? 1 : 0);
        end

        // R3 one core in C4 alone
        c0 = 3'd5; c1 = 3'd4; step(); step();
        chk("R3 single C4 state", pkg_state, 3);
        chk("R3 single C4 sleep", sleep_req, 0);

        // R4 drop without an edge
        c1 = 3'd5; step(); step();
        chk("R4 deep", sleep_req, 1);
        #3 c0 = 3'd4; #1;
        chk("R4 same-cycle drop", sleep_req, 0);

        // R8 stop-clock priority
        c0 = 3'd5; step(); step();
        chk("R8 pre", sleep_req, 1);
        #3 stop_clk = 1'b1; #1;
        chk("R8 sleep off", sleep_req, 0);
        step();
        chk("R8 shows light", pkg_state, 3);
        stop_clk = 1'b0; step(); step();

        // R5 and R7: entry from light idle, restore after cores wake
        c0 = 3'd4; c1 = 3'd3; step();
        enter_sg(5'd1, 1);
        c0 = 3'd0;
        stop_clk = 1'b0;
        step();
        chk("R7 restore", pkg_state, 3);
        step();
        chk("R7 track", pkg_state, 0);
        enter_sg(5'd20, 20);
        stop_clk = 1'b0; step(); step();
        chk("R6 no err in range", timer_err, 0);

        // R5 random in-range delays
        for (int i = 0; i < 6; i++) begin
            int d = $urandom_range(1, 20);
            enter_sg(5'(d), d);
            stop_clk = 1'b0; step(); step();
        end

        // R9 strobe with stop-clock low is ignored
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        stop_clk = 1'b1; delay_cfg = 5'd2;
        for (int k = 0; k < 25; k++) begin
            step();
            if (pkg_state == 2'd1) chk("R9 ignored strobe", pkg_state, 0);
        end
        chk("R9 no entry", pkg_state, 0);

        // R10 abort before entry
        stop_clk = 1'b0; step();
        stop_clk = 1'b1; delay_cfg = 5'd10; step();
        ack_resp = 1'b1; step(); ack_resp = 1'b0;
        step(); step(); step();
        stop_clk = 1'b0;
        for (int k = 0; k < 12; k++) begin
            step();
            if (sg_enter) chk("R10 abort strobe", sg_enter, 0);
        end
        stop_clk = 1'b1;
        for (int k = 0; k < 25; k++) step();
        chk("R10 no entry", pkg_state, 0);
        stop_clk = 1'b0; step();

        // R6 out-of-range delays
        enter_sg(5'd0, 20);
        chk("R6 err set", timer_err, 1);
        stop_clk = 1'b0; step(); step();
        chk("R6 err sticky", timer_err, 1);
        enter_sg(5'd27, 20);
        stop_clk = 1'b0; step();

        // R11 reset clears error
        rst_n = 1'b0; step();
        chk("R11 err clear", timer_err, 0);
        chk("R11 state again", pkg_state, 0);
        rst_n = 1'b1; step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule